// File: doc/BRIEF.md
# Attention and Idle-Timeout Notifier

This block gathers attention requests from attached devices into a flag word and tells the host about them with out-of-band symbols on the serial link. Devices set flag bits with single-cycle pulses. The command engine fetches the word and clears it with one read-clear strobe. A configuration write turns on notification and the idle timer.

Once notification is on, each newly raised flag queues one attention symbol. Once the idle timer is on, the block queues a symbol after each stretch of link silence of programmable length. When the host sends an attention-poll symbol, the block queues a reply. Every queued symbol is chosen when it is issued, and it depends on the flag state: it is the attention symbol when any flag is pending and the idle symbol otherwise. Requests go to the transmitter through a request/acknowledge pair. They are held back while a reply frame is on the wire.

Top module: `attn_notifier`

## Requirements
- R1: A 1 on any bit of `attn_pulse` sets the matching bit of `attn_flags` on the next clock edge. Set bits stay set until a read-clear, and `attn_any` is the OR of all flags.
- R2: A cycle with `attn_rdclr` high clears every flag, so `attn_any` reads 0 afterwards. The exception is a bit pulsed in that same cycle, which ends up set.
- R3: A write with `cfg_we` high and `cfg_addr` equal to 0xFF loads the configuration. Bit 15 enables notification, bit 14 enables the idle timer, and bits [7:0] hold the timeout value `ito`. Writes to any other address change nothing.
- R4: With notification on, a pulse on a flag that is currently clear queues exactly one symbol. A pulse on a bit that is already set queues nothing, and with notification off pulses queue nothing.
- R5: `oob_sym` is 0x104 (attention) while any flag is set and 0x100 (idle) otherwise. It is evaluated when the symbol is issued.
- R6: With the timer on and nothing queued, a symbol is queued exactly (ito+1)*20 clocks after the last restart. A restart is the edge that enabled the timer or the edge of the last restart event.
- R7: The timer restarts on `tx_activity`, on an accepted symbol (`oob_req` and `oob_ack` high together), and while `tx_busy` is high.
- R8: A received symbol 0x104 (`rx_oob_valid` high) queues one reply. Consecutive polls queue one reply each, up to three outstanding. A received 0x100 or any other value queues nothing.
- R9: `oob_req` is low while `tx_busy` is high. A queued symbol is held until it is accepted and is presented once `tx_busy` falls.
- R10: After reset all flags are clear, the configuration is zero and `oob_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| attn_pulse | input | 16 | Per-device attention set pulses |
| attn_rdclr | input | 1 | Read-clear strobe from the attention command |
| attn_flags | output | 16 | Current flag word (read data of the attention command) |
| attn_any | output | 1 | OR of all flags, the status attention bit |
| cfg_we | input | 1 | Init write strobe |
| cfg_addr | input | 8 | Init write address |
| cfg_wdata | input | 16 | Init write data |
| rx_oob_valid | input | 1 | A received out-of-band symbol is present |
| rx_oob_sym | input | 9 | Received out-of-band symbol |
| tx_busy | input | 1 | A reply frame is being transmitted |
| tx_activity | input | 1 | A byte or symbol was transmitted this cycle |
| oob_req | output | 1 | Request to send an out-of-band symbol |
| oob_sym | output | 9 | Symbol to send |
| oob_ack | input | 1 | Transmitter accepts the symbol |

## Verification
The assertions assume that `oob_ack` is raised only while `oob_req` is high. They also assume that no more than three requests are outstanding at once, so the saturating queue count never drops a request the checks count on. The stimulus raises acknowledge for a single cycle, and only after it has seen a request. It never issues more than two polls or events before it drains them. The timer windows are measured from the stimulus edge that enabled the timer, and from the edge of each restart event.

// File: rtl/attn_notifier.sv
module attn_notifier #(
  parameter int NFLAG    = 16,
  parameter int AW       = 8,
  parameter int DW       = 16,
  parameter int ITOW     = 8,
  parameter int PRESC    = 20,
  parameter logic [AW-1:0] CFG_ADDR = 8'hFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] attn_pulse,
  input  logic             attn_rdclr,
  output logic [NFLAG-1:0] attn_flags,
  output logic             attn_any,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [DW-1:0]    cfg_wdata,
  input  logic             rx_oob_valid,
  input  logic [8:0]       rx_oob_sym,
  input  logic             tx_busy,
  input  logic             tx_activity,
  output logic             oob_req,
  input  logic             oob_ack,
  output logic [8:0]       oob_sym
);
  localparam int PW = (PRESC > 1) ? $clog2(PRESC) : 1;
  localparam logic [8:0] SYM_IDLE = 9'h100;
  localparam logic [8:0] SYM_ATTN = 9'h104;

  logic [NFLAG-1:0] flags;
  logic             notif_en, ito_en;
  logic [ITOW-1:0]  ito, tick_cnt;
  logic [PW-1:0]    presc;
  logic [1:0]       pend;

  wire cfg_hit  = cfg_we && (cfg_addr == CFG_ADDR);
  wire rise     = notif_en && |(attn_pulse & ~flags);
  wire poll_hit = rx_oob_valid && (rx_oob_sym == SYM_ATTN);
  wire take     = oob_req && oob_ack;
  wire restart  = !ito_en || tx_busy || tx_activity || take || (pend != 2'd0);
  wire tick     = (presc == PW'(PRESC - 1));
  wire expire   = !restart && tick && (tick_cnt == ito);

  wire [2:0] pend_sum = {1'b0, pend} + {2'b0, rise} + {2'b0, expire}
                        + {2'b0, poll_hit} - {2'b0, take};

  assign attn_flags = flags;
  assign attn_any   = |flags;
  assign oob_req    = (pend != 2'd0) && !tx_busy;
  assign oob_sym    = attn_any ? SYM_ATTN : SYM_IDLE;

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= (attn_rdclr ? '0 : flags) | attn_pulse;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      notif_en <= 1'b0;
      ito_en   <= 1'b0;
      ito      <= '0;
    end else if (cfg_hit) begin
      notif_en <= cfg_wdata[15];
      ito_en   <= cfg_wdata[14];
      ito      <= cfg_wdata[ITOW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      presc    <= '0;
      tick_cnt <= '0;
    end else if (tick) begin
      presc    <= '0;
      tick_cnt <= (tick_cnt == ito) ? '0 : tick_cnt + 1'b1;
    end else begin
      presc    <= presc + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                pend <= 2'd0;
    else if (pend_sum > 3'd3)  pend <= 2'd3;
    else                       pend <= pend_sum[1:0];
  end

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !attn_rdclr |=> ((attn_flags & $past(attn_flags)) == $past(attn_flags))); // R1
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    attn_rdclr |=> ((attn_flags & ~$past(attn_pulse)) == '0)); // R2
  AST_CFG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_hit |=> $stable({notif_en, ito_en, ito})); // R3
  AST_NO_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!notif_en && !ito_en && !poll_hit) |=> (pend <= $past(pend))); // R4
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (oob_req && !oob_ack) |=> (oob_req || tx_busy)); // R9
endmodule

// File: tb/attn_notifier_bench.sv
`timescale 1ns/1ps
module attn_notifier_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] attn_pulse;
  logic        attn_rdclr;
  logic [15:0] attn_flags;
  logic        attn_any;
  logic        cfg_we;
  logic [7:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic        rx_oob_valid;
  logic [8:0]  rx_oob_sym;
  logic        tx_busy, tx_activity;
  logic        oob_req, oob_ack;
  logic [8:0]  oob_sym;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  attn_notifier u_attn_notifier (
    .clk(clk), .rst_n(rst_n), .attn_pulse(attn_pulse), .attn_rdclr(attn_rdclr),
    .attn_flags(attn_flags), .attn_any(attn_any), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .rx_oob_valid(rx_oob_valid),
    .rx_oob_sym(rx_oob_sym), .tx_busy(tx_busy), .tx_activity(tx_activity),
    .oob_req(oob_req), .oob_ack(oob_ack), .oob_sym(oob_sym)
  );

  // {pulse, rdclr, expected flags after the edge}
  localparam logic [32:0] VEC [6] = '{
    {16'h0004, 1'b0, 16'h0004},
    {16'h0100, 1'b0, 16'h0104},
    {16'h0000, 1'b1, 16'h0000},
    {16'h8001, 1'b1, 16'h8001},
    {16'h8000, 1'b0, 16'h8001},
    {16'h0000, 1'b1, 16'h0000}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    attn_pulse = '0; attn_rdclr = 0; cfg_we = 0; rx_oob_valid = 0;
    oob_ack = 0; tx_activity = 0;
  endtask

  task automatic cfg(input logic [7:0] a, input logic [15:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d; step();
  endtask

  task automatic ack();
    oob_ack = 1; step();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    rst_n = 0; attn_pulse = '0; attn_rdclr = 0; cfg_we = 0; cfg_addr = '0;
    cfg_wdata = '0; rx_oob_valid = 0; rx_oob_sym = '0; tx_busy = 0;
    tx_activity = 0; oob_ack = 0;
    repeat (3) step();
    chk("R10 flags", attn_flags, 16'h0);
    chk("R10 req", {15'b0, oob_req}, 16'h0);
    rst_n = 1;
    step();

    foreach (VEC[i]) begin
      attn_pulse = VEC[i][32:17]; attn_rdclr = VEC[i][16];
      step();
      chk("R1/R2 flags", attn_flags, VEC[i][15:0]);
      chk("R1 any", {15'b0, attn_any}, {15'b0, |VEC[i][15:0]});
      chk("R4 disabled no req", {15'b0, oob_req}, 16'h0);
    end

    cfg(8'h12, 16'hC001);
    attn_pulse = 16'h0001; step();
    repeat (3) step();
    chk("R3 other address ignored", {15'b0, oob_req}, 16'h0);
    attn_rdclr = 1; step();
    chk("R2 cleared", attn_flags, 16'h0);

    cfg(8'hFF, 16'h8000);
    attn_pulse = 16'h0001; step();
    chk("R4 new flag req", {15'b0, oob_req}, 16'h1);
    chk("R5 attn symbol", {7'b0, oob_sym}, 16'h0104);
    attn_pulse = 16'h0001; step();
    chk("R9 held", {15'b0, oob_req}, 16'h1);
    ack();
    chk("R4 exactly one", {15'b0, oob_req}, 16'h0);

    tx_busy = 1; attn_pulse = 16'h0002; step();
    chk("R9 busy blocks", {15'b0, oob_req}, 16'h0);
    repeat (3) step();
    chk("R9 busy still blocks", {15'b0, oob_req}, 16'h0);
    tx_busy = 0; step();
    chk("R9 after busy", {15'b0, oob_req}, 16'h1);
    ack();
    chk("R9 taken", {15'b0, oob_req}, 16'h0);

    attn_rdclr = 1; step();
    chk("R2 any zero", {15'b0, attn_any}, 16'h0);
    rx_oob_valid = 1; rx_oob_sym = 9'h100; step();
    chk("R8 idle ignored", {15'b0, oob_req}, 16'h0);
    rx_oob_valid = 1; rx_oob_sym = 9'h104; step();
    chk("R8 poll answered", {15'b0, oob_req}, 16'h1);
    chk("R5 idle symbol", {7'b0, oob_sym}, 16'h0100);
    ack();
    chk("R8 single reply", {15'b0, oob_req}, 16'h0);
    rx_oob_valid = 1; rx_oob_sym = 9'h104; step();
    rx_oob_valid = 1; rx_oob_sym = 9'h104; step();
    ack();
    chk("R8 second reply", {15'b0, oob_req}, 16'h1);
    ack();
    chk("R8 drained", {15'b0, oob_req}, 16'h0);

    cfg(8'hFF, 16'hC009);
    repeat (199) step();
    chk("R6 not yet", {15'b0, oob_req}, 16'h0);
    step();
    chk("R6 expiry", {15'b0, oob_req}, 16'h1);
    chk("R5 idle from timer", {7'b0, oob_sym}, 16'h0100);
    ack();
    repeat (150) step();
    tx_activity = 1; step();
    repeat (199) step();
    chk("R7 restart by activity", {15'b0, oob_req}, 16'h0);
    step();
    chk("R7 expiry after restart", {15'b0, oob_req}, 16'h1);
    ack();

    attn_pulse = 16'h0010; step();
    chk("R4 attn req", {15'b0, oob_req}, 16'h1);
    ack();
    repeat (199) step();
    chk("R7 restart by accept", {15'b0, oob_req}, 16'h0);
    step();
    chk("R6 attn from timer", {7'b0, oob_sym}, 16'h0104);
    chk("R6 req", {15'b0, oob_req}, 16'h1);
    ack();

    cfg(8'hFF, 16'h0000);
    attn_pulse = 16'h0020; step();
    repeat (300) step();
    chk("R3 disabled quiet", {15'b0, oob_req}, 16'h0);
    chk("R1 flags kept", attn_flags, 16'h0030);

    finish_run();
  end
endmodule